// File: doc/BRIEF.md
# Paired-Strobe Transmit Word Queue

This block builds 31-bit transmit words out of two writes on a 16-bit data bus and keeps them in an eight-slot first-in first-out store until a downstream serializer takes them. A low-half strobe latches the bottom sixteen bits of a word. The high-half strobe that follows supplies the top fifteen bits and commits the whole word to the next free slot. A high-half strobe with no pending low half is dropped. A commit into a full store is also dropped, and the stored words are left untouched.

The serializer sees the oldest stored word on a valid/data pair and removes it with a take pulse. When it has finished sending a word on the line, it reports that with a sent pulse. A word counter keeps track of how many committed words have not yet been sent. The transmit-ready flag is high only when that count is zero, so it stays low while the last word is still being serialized, even after the store has drained. The reset input asserts asynchronously and is released synchronously. It empties the store, drops any half-built word and clears the word count.

Top module: `tx_word_queue`

## Requirements
- R1: Two clock edges after reset is released, pop_valid and q_full are 0 and tx_ready is 1.
- R2: A load_lo pulse latches bus_data[15:0] as word bits 15:0. A later load_hi pulse commits the word with bits 30:16 taken from bus_data[14:0]. bus_data[15] is ignored at the load_hi pulse.
- R3: A load_hi pulse with no load_lo pulse since the last commit (or since reset) does not queue a word.
- R4: When load_lo pulses more than once before load_hi, the most recent low half is the one committed.
- R5: The store holds up to 8 words and returns them oldest first. q_full is 1 exactly while 8 words are held.
- R6: A commit while the store is full and no word is taken in the same cycle is dropped. The stored words and their order stay unchanged, and the pending low half is used up.
- R7: pop_valid is 1 whenever at least one word is held, and pop_data then shows the oldest word. A cycle with pop_valid and pop_take both high removes that word. The result is visible after that clock edge.
- R8: A take and a commit in the same cycle are both carried out, even when the store is full. After such a cycle on a full store, q_full stays 1.
- R9: tx_ready equals 1 exactly when the number of committed words equals the number of word_sent pulses counted. Taking a word does not raise it.
- R10: A word_sent pulse while no committed word is outstanding is ignored.
- R11: When load_lo and load_hi pulse in the same cycle, load_hi acts on the low half held before that cycle, and load_lo then latches a new low half.
- R12: Driving rst_n low at any time immediately clears pop_valid and q_full and sets tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_data | input | 16 | Shared write data bus |
| load_lo | input | 1 | Low-half strobe, one pulse per cycle high |
| load_hi | input | 1 | High-half strobe that commits the word |
| pop_take | input | 1 | Serializer takes the oldest word |
| word_sent | input | 1 | Serializer finished sending one word |
| pop_valid | output | 1 | A stored word is available |
| pop_data | output | 31 | Oldest stored word |
| q_full | output | 1 | All 8 slots occupied |
| tx_ready | output | 1 | Every committed word has been sent |

## Verification
Commits, takes and sent pulses are all registered on the edge where the strobe is high. pop_valid, pop_data, q_full and tx_ready therefore change one edge after the stimulus, with no further delay. The bench drives inputs 1 ns after a rising edge and checks the outputs 1 ns after the next rising edge, so each result is read in the first cycle it is due. Reset release takes two edges through the synchronizer, and the bench waits three before its first check. The effect of an asynchronous reset is checked 1 ns after rst_n falls, without waiting for a clock edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned WORD_W = 31;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned LO_W   = 16;
  localparam int unsigned HI_W   = WORD_W - LO_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LO_W-1:0]   lo_t;
endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/txq_assembler.sv
module txq_assembler
  import txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             load_lo,
  input  logic             load_hi,
  output logic             armed,
  output logic             commit,
  output word_t            commit_word
);
  lo_t  lo_q, lo_d;
  logic lo_en;
  logic armed_q, armed_d;

  // load_hi consumes the half held before this cycle; load_lo then re-arms
  always_comb begin
    armed_d = armed_q;
    lo_d    = bus_data[LO_W-1:0];
    lo_en   = load_lo;
    if (load_hi) armed_d = 1'b0;
    if (load_lo) armed_d = 1'b1;
  end

  assign commit      = load_hi && armed_q;
  assign commit_word = {bus_data[HI_W-1:0], lo_q};
  assign armed       = armed_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= lo_d;
  end
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       wr_req,
  input  word_t                      wr_word,
  input  logic                       rd_req,
  output logic                       wr_accept,
  output logic                       rd_fire,
  output word_t                      head_word,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  word_t             slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [OCC_W-1:0]  occ_q, occ_d;

  assign full      = (occ_q == OCC_W'(DEPTH));
  assign empty     = (occ_q == '0);
  assign rd_fire   = rd_req && !empty;
  assign wr_accept = wr_req && (!full || rd_fire);
  assign head_word = slot_q[rd_ptr_q];
  assign occ       = occ_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (wr_accept) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_fire)   rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (wr_accept && !rd_fire) occ_d = occ_q + 1'b1;
    if (!wr_accept && rd_fire) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_accept && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_word;
    end
  end
endmodule

// File: rtl/txq_word_counter.sv
module txq_word_counter #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic inc,
  input  logic sent,
  output logic idle
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up, down;

  always_comb begin
    up    = inc && (cnt_q != CNT_MAX);
    down  = sent && (cnt_q != '0);
    cnt_d = cnt_q;
    if (up && !down) cnt_d = cnt_q + 1'b1;
    if (!up && down) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/tx_word_queue.sv
module tx_word_queue
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              pop_take,
  input  logic              word_sent,
  output logic              pop_valid,
  output logic [WORD_W-1:0] pop_data,
  output logic              q_full,
  output logic              tx_ready
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic             rst_ni;
  logic             armed, commit, wr_accept, rd_fire, empty;
  word_t            commit_word, head_word;
  logic [OCC_W-1:0] occ;

  txq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  txq_assembler u_asm (
    .clk(clk), .rst_ni(rst_ni), .bus_data(bus_data),
    .load_lo(load_lo), .load_hi(load_hi), .armed(armed),
    .commit(commit), .commit_word(commit_word)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_ni(rst_ni), .wr_req(commit), .wr_word(commit_word),
    .rd_req(pop_take), .wr_accept(wr_accept), .rd_fire(rd_fire),
    .head_word(head_word), .occ(occ), .full(q_full), .empty(empty)
  );

  txq_word_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .inc(wr_accept), .sent(word_sent),
    .idle(tx_ready)
  );

  assign pop_valid = !empty;
  assign pop_data  = head_word;
endmodule

// File: rtl/tx_word_queue_chk.sv
module tx_word_queue_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_ni,
  input logic                       load_hi,
  input logic                       pop_take,
  input logic                       word_sent,
  input logic                       pop_valid,
  input logic [30:0]                pop_data,
  input logic                       q_full,
  input logic                       tx_ready,
  input logic                       armed,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  a_r9_ready_implies_empty: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_ready |-> !pop_valid);

  a_r5_full_has_data: assert property (@(posedge clk) disable iff (!rst_ni)
    q_full |-> pop_valid);

  a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    occ <= OCC_W'(DEPTH));

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    (q_full && load_hi && !pop_take) |=> (q_full && $stable(pop_data)));

  a_r3_orphan_hi: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_hi && !armed && !(pop_take && pop_valid)) |=> (occ == $past(occ)));

  a_r7_take_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_valid && pop_take && !(load_hi && armed)) |=> (occ == $past(occ) - 1'b1));

  a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_ni)
    (q_full && pop_take && load_hi && armed) |=> q_full);

  a_r9_rise_on_sent: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(tx_ready) |-> $past(word_sent));
endmodule

bind tx_word_queue tx_word_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .load_hi(load_hi), .pop_take(pop_take),
  .word_sent(word_sent), .pop_valid(pop_valid), .pop_data(pop_data),
  .q_full(q_full), .tx_ready(tx_ready), .armed(armed), .occ(occ)
);

// File: tb/tx_word_queue_test.sv
module tx_word_queue_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic        load_lo, load_hi, pop_take, word_sent;
  logic        pop_valid, q_full, tx_ready;
  logic [30:0] pop_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [30:0] mq[$];
  int outst = 0;

  always #2.5 clk = ~clk;

  tx_word_queue uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .load_lo(load_lo),
    .load_hi(load_hi), .pop_take(pop_take), .word_sent(word_sent),
    .pop_valid(pop_valid), .pop_data(pop_data), .q_full(q_full),
    .tx_ready(tx_ready)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] pat(int i);
    logic [31:0] t;
    t = (32'h5A3C_1E0F * (i + 3)) ^ (32'(i) << 20);
    return t[30:0];
  endfunction

  task automatic model_commit(logic [30:0] w, bit popping);
    if (mq.size() < 8 || popping) begin
      mq.push_back(w);
      outst++;
    end
  endtask

  // R2: bus bit 15 is driven high at the high-half strobe and must not appear
  task automatic load_word(logic [30:0] w);
    load_lo = 1'b1; bus_data = w[15:0]; tick();
    load_lo = 1'b0; load_hi = 1'b1; bus_data = {1'b1, w[30:16]};
    model_commit(w, 1'b0);
    tick();
    load_hi = 1'b0;
  endtask

  task automatic take_word(string req);
    chk(req, 32'(pop_valid), 32'd1);
    chk(req, 32'(pop_data), 32'(mq[0]));
    pop_take = 1'b1; tick(); pop_take = 1'b0;
    void'(mq.pop_front());
    chk(req, 32'(pop_valid), 32'(mq.size() != 0));
  endtask

  task automatic sent_word;
    word_sent = 1'b1; tick(); word_sent = 1'b0;
    if (outst > 0) outst--;
  endtask

  task automatic ready_chk(string req);
    chk(req, 32'(tx_ready), 32'(outst == 0));
  endtask

  task automatic do_reset;
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1; tick(); tick(); tick();
    mq.delete(); outst = 0;
  endtask

  initial begin : watchdog
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_data = '0; load_lo = 0; load_hi = 0; pop_take = 0; word_sent = 0;
    do_reset();
    chk("R1 pop_valid", 32'(pop_valid), 32'd0);
    chk("R1 q_full", 32'(q_full), 32'd0);
    chk("R1 tx_ready", 32'(tx_ready), 32'd1);

    // R3: orphan high strobe
    load_hi = 1'b1; bus_data = 16'h7FFF; tick(); load_hi = 1'b0;
    chk("R3 orphan valid", 32'(pop_valid), 32'd0);
    chk("R3 orphan ready", 32'(tx_ready), 32'd1);

    // R11: both strobes together with nothing armed, then a lone high strobe
    load_lo = 1'b1; load_hi = 1'b1; bus_data = 16'hBEEF; tick();
    load_lo = 1'b0; load_hi = 1'b0;
    chk("R11 same-cycle no commit", 32'(pop_valid), 32'd0);
    load_hi = 1'b1; bus_data = 16'h8123; model_commit({15'h0123, 16'hBEEF}, 1'b0); tick();
    load_hi = 1'b0;
    chk("R11 later commit data", 32'(pop_data), 32'({15'h0123, 16'hBEEF}));
    ready_chk("R9 falls on commit");
    take_word("R7 take single");
    ready_chk("R9 not raised by take");
    sent_word();
    ready_chk("R9 raised by sent");

    // R4: latest low half wins
    load_lo = 1'b1; bus_data = 16'h1111; tick();
    bus_data = 16'h2222; tick(); load_lo = 1'b0;
    load_hi = 1'b1; bus_data = 16'h0333; model_commit({15'h0333, 16'h2222}, 1'b0); tick();
    load_hi = 1'b0;
    chk("R4 latest low", 32'(pop_data), 32'({15'h0333, 16'h2222}));
    take_word("R4 take"); sent_word(); ready_chk("R4 ready");

    // R5/R6: fill, overfill, drain in order
    for (int i = 0; i < 8; i++) begin
      load_word(pat(i));
      chk("R5 full flag", 32'(q_full), 32'(i == 7));
      chk("R2 head word", 32'(pop_data), 32'(pat(0)));
    end
    load_word(pat(99));
    chk("R6 stays full", 32'(q_full), 32'd1);
    chk("R6 head kept", 32'(pop_data), 32'(pat(0)));
    // R6: pairing was used up, so a lone high strobe after a take adds nothing
    take_word("R6 take");
    load_hi = 1'b1; bus_data = 16'h0055; tick(); load_hi = 1'b0;
    chk("R6 pair consumed", 32'(q_full), 32'd0);
    while (mq.size() != 0) take_word("R5 order");
    for (int i = 0; i < 8; i++) begin
      ready_chk("R9 waits for all sent");
      sent_word();
    end
    ready_chk("R9 all sent");

    // R10: spurious sent pulse ignored
    sent_word(); sent_word();
    load_word(pat(40));
    ready_chk("R10 spurious sent ignored");
    take_word("R10 take"); sent_word(); ready_chk("R10 ready");

    // R8: take and commit together on a full store
    for (int i = 0; i < 8; i++) load_word(pat(10 + i));
    load_lo = 1'b1; bus_data = pat(50)[15:0]; tick(); load_lo = 1'b0;
    chk("R8 head before swap", 32'(pop_data), 32'(pat(10)));
    load_hi = 1'b1; pop_take = 1'b1; bus_data = {1'b0, pat(50)[30:16]};
    void'(mq.pop_front()); model_commit(pat(50), 1'b1);
    tick();
    load_hi = 1'b0; pop_take = 1'b0;
    chk("R8 still full", 32'(q_full), 32'd1);
    while (mq.size() != 0) take_word("R8 order");

    // R12: asynchronous reset mid-operation
    load_word(pat(60)); load_word(pat(61));
    #1 rst_n = 1'b0; #1;
    chk("R12 valid cleared", 32'(pop_valid), 32'd0);
    chk("R12 full cleared", 32'(q_full), 32'd0);
    chk("R12 ready set", 32'(tx_ready), 32'd1);
    tick(); rst_n = 1'b1; tick(); tick(); tick();
    mq.delete(); outst = 0;
    load_hi = 1'b1; bus_data = 16'h0001; tick(); load_hi = 1'b0;
    chk("R12 half word dropped", 32'(pop_valid), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule